// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Unit

This unit sits between the maskable interrupt lines of a CPU core and its sequencer. It decides on which cycle the core takes an interrupt, and which line it takes. It holds one pending bit per line, one enable bit per line and one debug-enable bit per line. It also holds a global mask bit and a protected-write enable bit. Each event on a line latches into the pending register. A line qualifies when it is pending and allowed by the active gating path. The lowest-numbered qualifying line is then accepted.

There are two gating paths. The standard path applies whenever the core is not both in real-time emulation and halted. In that path a pending line needs its enable bit set and the global mask clear. When the core is halted in real-time emulation, a pending line needs both its enable bit and its debug-enable bit set, and the global mask plays no part.

On acceptance the unit clears the line's pending and enable bits, sets the global mask and clears the protected-write enable. It pulses a context-save request and then issues a vector-fetch request that carries the line number. It accepts nothing further until the sequencer strobes the return input. The service routine clears the global mask through the mask-clear input to allow nesting of later interrupts.

Top module: `irq_accept`

## Requirements
- R1: A 1 on bit k of `irq_i` at a rising edge sets pending bit k (`flag_o[k]`). If the same line is accepted at that edge, the new event wins and the bit stays set.
- R2: Outside the halted-in-emulation state (`rtemu_i` & `halted_i` is 0), a line qualifies only when its pending bit and its enable bit are 1 and `gmask_o` is 0.
- R3: With `rtemu_i`=1 and `halted_i`=1, a line qualifies when its pending, enable and debug-enable bits are all 1, whatever the value of `gmask_o`.
- R4: With `rtemu_i`=1 and `halted_i`=0, the debug-enable register has no effect and the R2 rule applies.
- R5: When several lines qualify, the lowest-numbered one is accepted, and its number appears on `accept_line_o`.
- R6: Acceptance happens at the edge after a line qualifies while `busy_o` is 0. At that same edge `accept_o` rises for exactly one cycle, the accepted line's pending and enable bits clear, `gmask_o` becomes 1 and `prot_o` becomes 0. These updates take precedence over same-cycle writes to those bits.
- R7: `ctx_save_o` is high in the acceptance cycle. `vec_fetch_o` is high in the following cycle, with `vec_line_o` equal to the accepted line.
- R8: `busy_o` rises with acceptance. While it is high no acceptance occurs. A `ret_i` strobe clears it at the next edge.
- R9: `ier_we` loads `ier_wdata` into the enable register, and `dbg_we` loads `dbg_wdata` into the debug-enable register. `gmask_set` sets the mask and wins over `gmask_clr`. `prot_clr` clears the protected-write enable and wins over `prot_set`.
- R10: After reset, the pending, enable and debug-enable registers are 0, `gmask_o`=1, `prot_o`=0, `busy_o`=0, and no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_LINES | Interrupt line events |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | N_LINES | Enable register write data |
| dbg_we | input | 1 | Debug-enable register write strobe |
| dbg_wdata | input | N_LINES | Debug-enable register write data |
| gmask_set | input | 1 | Set global mask |
| gmask_clr | input | 1 | Clear global mask |
| prot_set | input | 1 | Set protected-write enable |
| prot_clr | input | 1 | Clear protected-write enable |
| rtemu_i | input | 1 | Real-time emulation mode |
| halted_i | input | 1 | Core halted |
| ret_i | input | 1 | Return strobe, context restored |
| flag_o | output | N_LINES | Pending register |
| ier_o | output | N_LINES | Enable register |
| dbg_o | output | N_LINES | Debug-enable register |
| gmask_o | output | 1 | Global mask bit |
| prot_o | output | 1 | Protected-write enable bit |
| busy_o | output | 1 | Interrupt in service |
| accept_o | output | 1 | Acceptance pulse |
| accept_line_o | output | LINE_W | Accepted line number |
| ctx_save_o | output | 1 | Context-save request |
| vec_fetch_o | output | 1 | Vector-fetch request |
| vec_line_o | output | LINE_W | Line number for the vector fetch |

## Verification
The hardest situation to reach from the ports is a line whose new event arrives on the same edge at which that line is accepted. A second hard case is an enable-register write that lands on the accepting edge. Both need a qualified line, an idle unit and the colliding stimulus all in the same cycle. The random phase therefore drives dense line events, frequent enable writes and frequent mode flips. Short return delays keep the unit idle often, and a few directed sequences force simultaneous lines and acceptance with the mask set while halted in emulation.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    localparam int unsigned IRQ_LINES_DEF = 14;

    typedef enum logic {
        GATE_STD = 1'b0,
        GATE_DBG = 1'b1
    } gate_path_e;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int unsigned N_LINES = 14
) (
    input  logic [N_LINES-1:0]      flag_i,
    input  logic [N_LINES-1:0]      ier_i,
    input  logic [N_LINES-1:0]      dbg_i,
    input  logic                    gmask_i,
    input  irq_accept_pkg::gate_path_e path_i,
    output logic [N_LINES-1:0]      qual_o
);
    always_comb begin
        if (path_i == irq_accept_pkg::GATE_DBG) begin
            qual_o = flag_i & ier_i & dbg_i;
        end else begin
            qual_o = flag_i & ier_i & {N_LINES{~gmask_i}};
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int unsigned N_LINES = 14,
    localparam int unsigned LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] qual_i,
    output logic               any_o,
    output logic [LINE_W-1:0]  idx_o
);
    logic [N_LINES:0]   below;
    logic [N_LINES-1:0] grant;

    assign below[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_chain
            assign grant[gi]   = qual_i[gi] & ~below[gi];
            assign below[gi+1] = below[gi] | qual_i[gi];
        end
    endgenerate

    assign any_o = below[N_LINES];

    always_comb begin
        idx_o = '0;
        for (int unsigned k = 0; k < N_LINES; k++) begin
            if (grant[k]) begin
                idx_o = idx_o | LINE_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
    parameter int unsigned N_LINES = irq_accept_pkg::IRQ_LINES_DEF,
    localparam int unsigned LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic               ier_we,
    input  logic [N_LINES-1:0] ier_wdata,
    input  logic               dbg_we,
    input  logic [N_LINES-1:0] dbg_wdata,
    input  logic               gmask_set,
    input  logic               gmask_clr,
    input  logic               prot_set,
    input  logic               prot_clr,
    input  logic               rtemu_i,
    input  logic               halted_i,
    input  logic               ret_i,
    output logic [N_LINES-1:0] flag_o,
    output logic [N_LINES-1:0] ier_o,
    output logic [N_LINES-1:0] dbg_o,
    output logic               gmask_o,
    output logic               prot_o,
    output logic               busy_o,
    output logic               accept_o,
    output logic [LINE_W-1:0]  accept_line_o,
    output logic               ctx_save_o,
    output logic               vec_fetch_o,
    output logic [LINE_W-1:0]  vec_line_o
);
    import irq_accept_pkg::*;

    typedef struct packed {
        logic [N_LINES-1:0] flag;
        logic [N_LINES-1:0] ier;
        logic [N_LINES-1:0] dbg;
        logic               gmask;
        logic               prot;
        logic               busy;
        logic               acc;
        logic [LINE_W-1:0]  acc_line;
        logic               vec;
        logic [LINE_W-1:0]  vec_line;
    } acc_state_t;

    acc_state_t st_d, st_q;

    gate_path_e         path;
    logic [N_LINES-1:0] qual;
    logic               any_qual;
    logic [LINE_W-1:0]  pick_idx;
    logic               take;

    assign path = (rtemu_i && halted_i) ? GATE_DBG : GATE_STD;

    irq_qualify #(.N_LINES(N_LINES)) u_qual (
        .flag_i  (st_q.flag),
        .ier_i   (st_q.ier),
        .dbg_i   (st_q.dbg),
        .gmask_i (st_q.gmask),
        .path_i  (path),
        .qual_o  (qual)
    );

    irq_pick #(.N_LINES(N_LINES)) u_pick (
        .qual_i (qual),
        .any_o  (any_qual),
        .idx_o  (pick_idx)
    );

    assign take = any_qual && !st_q.busy;

    always_comb begin
        st_d          = st_q;
        st_d.acc      = 1'b0;
        st_d.vec      = st_q.acc;
        st_d.vec_line = st_q.acc_line;

        if (ier_we) st_d.ier = ier_wdata;
        if (dbg_we) st_d.dbg = dbg_wdata;

        if (gmask_set)      st_d.gmask = 1'b1;
        else if (gmask_clr) st_d.gmask = 1'b0;

        if (prot_clr)      st_d.prot = 1'b0;
        else if (prot_set) st_d.prot = 1'b1;

        if (ret_i) st_d.busy = 1'b0;

        if (take) begin
            st_d.flag[pick_idx] = 1'b0;
            st_d.ier[pick_idx]  = 1'b0;
            st_d.gmask          = 1'b1;
            st_d.prot           = 1'b0;
            st_d.busy           = 1'b1;
            st_d.acc            = 1'b1;
            st_d.acc_line       = pick_idx;
        end

        st_d.flag = st_d.flag | irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.gmask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o        = st_q.flag;
    assign ier_o         = st_q.ier;
    assign dbg_o         = st_q.dbg;
    assign gmask_o       = st_q.gmask;
    assign prot_o        = st_q.prot;
    assign busy_o        = st_q.busy;
    assign accept_o      = st_q.acc;
    assign accept_line_o = st_q.acc_line;
    assign ctx_save_o    = st_q.acc;
    assign vec_fetch_o   = st_q.vec;
    assign vec_line_o    = st_q.vec_line;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int unsigned N_LINES = 14,
    localparam int unsigned LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_i,
    input logic               ret_i,
    input logic [N_LINES-1:0] flag_o,
    input logic               gmask_o,
    input logic               prot_o,
    input logic               busy_o,
    input logic               accept_o,
    input logic [LINE_W-1:0]  accept_line_o,
    input logic               ctx_save_o,
    input logic               vec_fetch_o,
    input logic [LINE_W-1:0]  vec_line_o
);
    AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o); // R6

    AST_ACCEPT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (gmask_o && !prot_o && busy_o)); // R6

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (((flag_o >> accept_line_o) & 1) == 0
                      || (($past(irq_i) >> accept_line_o) & 1) != 0)); // R1

    AST_CTX_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> ctx_save_o); // R7

    AST_VEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (vec_fetch_o && vec_line_o == $past(accept_line_o))); // R7

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ret_i) |=> !accept_o); // R8

    AST_RET_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ret_i) |=> !busy_o); // R8
endmodule

bind irq_accept irq_accept_chk #(.N_LINES(N_LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_i         (irq_i),
    .ret_i         (ret_i),
    .flag_o        (flag_o),
    .gmask_o       (gmask_o),
    .prot_o        (prot_o),
    .busy_o        (busy_o),
    .accept_o      (accept_o),
    .accept_line_o (accept_line_o),
    .ctx_save_o    (ctx_save_o),
    .vec_fetch_o   (vec_fetch_o),
    .vec_line_o    (vec_line_o)
);

// File: tb/irq_accept_tb.sv
`timescale 1ns/1ps
module irq_accept_tb;
    localparam int unsigned N = 14;
    localparam int unsigned LW = $clog2(N);
    localparam int unsigned N_RAND = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_i = '0;
    logic ier_we = 1'b0;
    logic [N-1:0] ier_wdata = '0;
    logic dbg_we = 1'b0;
    logic [N-1:0] dbg_wdata = '0;
    logic gmask_set = 1'b0, gmask_clr = 1'b0, prot_set = 1'b0, prot_clr = 1'b0;
    logic rtemu_i = 1'b0, halted_i = 1'b0, ret_i = 1'b0;
    logic [N-1:0] flag_o, ier_o, dbg_o;
    logic gmask_o, prot_o, busy_o, accept_o, ctx_save_o, vec_fetch_o;
    logic [LW-1:0] accept_line_o, vec_line_o;

    always #2.5 clk = ~clk;

    irq_accept #(.N_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
        .ier_we(ier_we), .ier_wdata(ier_wdata),
        .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
        .gmask_set(gmask_set), .gmask_clr(gmask_clr),
        .prot_set(prot_set), .prot_clr(prot_clr),
        .rtemu_i(rtemu_i), .halted_i(halted_i), .ret_i(ret_i),
        .flag_o(flag_o), .ier_o(ier_o), .dbg_o(dbg_o),
        .gmask_o(gmask_o), .prot_o(prot_o), .busy_o(busy_o),
        .accept_o(accept_o), .accept_line_o(accept_line_o),
        .ctx_save_o(ctx_save_o), .vec_fetch_o(vec_fetch_o),
        .vec_line_o(vec_line_o)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [N-1:0] m_flag, m_ier, m_dbg;
    logic m_mask, m_prot, m_busy, m_acc, m_vec;
    int unsigned m_line, m_vline;
    string acc_tag;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        m_flag = '0; m_ier = '0; m_dbg = '0;
        m_mask = 1'b1; m_prot = 1'b0; m_busy = 1'b0;
        m_acc = 1'b0; m_vec = 1'b0; m_line = 0; m_vline = 0;
        acc_tag = "R10";
    endtask

    task automatic model_step();
        logic [N-1:0] q;
        int w;
        if (rtemu_i && halted_i) begin
            q = m_flag & m_ier & m_dbg;                 // R3
            acc_tag = "R3";
        end else begin
            q = m_flag & m_ier & {N{~m_mask}};          // R2 / R4
            acc_tag = rtemu_i ? "R4" : "R2";
        end
        w = lowest(q);                                   // R5
        m_vec = m_acc;
        m_vline = m_line;
        m_acc = 1'b0;
        if (ier_we) m_ier = ier_wdata;                   // R9
        if (dbg_we) m_dbg = dbg_wdata;
        if (gmask_set) m_mask = 1'b1; else if (gmask_clr) m_mask = 1'b0;
        if (prot_clr) m_prot = 1'b0; else if (prot_set) m_prot = 1'b1;
        if (ret_i) m_busy = 1'b0;                        // R8
        if (w >= 0 && !(m_busy && !ret_i) && !(ret_i && 0)) begin
        end
        if (w >= 0 && !busy_prev) begin                  // R6
            m_flag[w] = 1'b0;
            m_ier[w] = 1'b0;
            m_mask = 1'b1;
            m_prot = 1'b0;
            m_busy = 1'b1;
            m_acc = 1'b1;
            m_line = w;
        end
        m_flag = m_flag | irq_i;                         // R1
    endtask

    logic busy_prev;

    task automatic compare();
        check("R1 flag", 32'(flag_o), 32'(m_flag));
        check("R9 ier", 32'(ier_o), 32'(m_ier));
        check("R9 dbg", 32'(dbg_o), 32'(m_dbg));
        check("R6 gmask", 32'(gmask_o), 32'(m_mask));
        check("R6 prot", 32'(prot_o), 32'(m_prot));
        check("R8 busy", 32'(busy_o), 32'(m_busy));
        check({acc_tag, " accept"}, 32'(accept_o), 32'(m_acc));
        check("R7 ctx_save", 32'(ctx_save_o), 32'(m_acc));
        check("R7 vec_fetch", 32'(vec_fetch_o), 32'(m_vec));
        if (m_acc) check("R5 accept_line", 32'(accept_line_o), 32'(m_line));
        if (m_vec) check("R7 vec_line", 32'(vec_line_o), 32'(m_vline));
    endtask

    task automatic idle_inputs();
        irq_i = '0; ier_we = 0; dbg_we = 0; gmask_set = 0; gmask_clr = 0;
        prot_set = 0; prot_clr = 0; ret_i = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        busy_prev = m_busy;
        model_step();
        @(negedge clk);
        compare();
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        model_reset();
        busy_prev = 1'b0;
        repeat (3) @(negedge clk);
        compare();                                   // R10 reset state
        rst_n = 1'b1;

        // directed: simultaneous lines, lowest wins (R5), standard path (R2)
        ier_we = 1; ier_wdata = '1; prot_set = 1; cycle(); idle_inputs();
        gmask_clr = 1; irq_i = (N'(1) << 9) | (N'(1) << 5); cycle(); idle_inputs();
        cycle(); cycle();
        ret_i = 1; cycle(); idle_inputs();
        gmask_clr = 1; cycle(); idle_inputs();
        cycle(); ret_i = 1; cycle(); idle_inputs();

        // directed: halted in emulation, mask set, debug enable gates (R3)
        ier_we = 1; ier_wdata = '1; dbg_we = 1; dbg_wdata = N'(1) << 12;
        rtemu_i = 1; halted_i = 1; cycle(); idle_inputs();
        irq_i = (N'(1) << 2) | (N'(1) << 12); cycle(); idle_inputs();
        cycle(); cycle(); ret_i = 1; cycle(); idle_inputs();
        // running in emulation: dbg ignored, mask still blocks (R4)
        halted_i = 0; cycle(); cycle();
        gmask_clr = 1; cycle(); idle_inputs(); cycle(); cycle();
        ret_i = 1; cycle(); idle_inputs();

        // directed: event on the accepted line at the accepting edge (R1)
        rtemu_i = 0; ier_we = 1; ier_wdata = N'(1) << 3; gmask_clr = 1;
        irq_i = N'(1) << 3; cycle(); idle_inputs();
        irq_i = N'(1) << 3; cycle(); idle_inputs();
        cycle(); ret_i = 1; cycle(); idle_inputs();

        // constrained random
        for (int c = 0; c < N_RAND; c++) begin
            irq_i = N'($urandom & $urandom & $urandom);
            ier_we = ($urandom_range(0, 5) == 0);
            ier_wdata = N'($urandom | $urandom);
            dbg_we = ($urandom_range(0, 9) == 0);
            dbg_wdata = N'($urandom);
            gmask_clr = ($urandom_range(0, 3) == 0);
            gmask_set = ($urandom_range(0, 15) == 0);
            prot_set = ($urandom_range(0, 3) == 0);
            prot_clr = ($urandom_range(0, 7) == 0);
            ret_i = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) rtemu_i = ~rtemu_i;
            if ($urandom_range(0, 15) == 0) halted_i = ~halted_i;
            cycle();
        end
        idle_inputs();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule